// File: doc/BRIEF.md
# Integer Compare Flag Generator

This block compares two integer operands held in a coprocessor register file and produces a 32-bit status word for the host processor. The host copies that word into its own condition flags. Each request carries a 32-bit instruction word. The block reads three fields from it: an operation select and two source register indices. It picks both operands out of a flattened image of the register file, which has `NREGS` entries of `XLEN` bits each. It then forms the difference A minus B and derives four condition flags from it.

There are two compare widths. The narrow compare looks only at the low 32-bit half of each register. The wide compare treats the whole 64-bit register as one signed value. Carry and overflow come from the sign bits of A, B and the difference. The four flags sit in the top nibble of the status word, and every other bit is zero. The result is registered: it appears one clock after the request, together with a one-cycle valid pulse. A request with any other select value raises an illegal-operation pulse and produces no flags.

Top module: `cmpf_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `flags_valid` and `illegal_op` are 0 and `flags_word` is all zeros.
- R2: A request with `req_valid` high and a supported select gives `flags_valid` high in the next cycle. That pulse lasts one cycle. A cycle with no request gives `flags_valid` and `illegal_op` low in the next cycle.
- R3: The status word holds N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27:0 are always zero.
- R4: The difference D is A minus B, wrapped to the compare width. Z is 1 exactly when D is zero. N is the sign bit of D.
- R5: V is 1 when A is negative, B is non-negative and D is non-negative. V is also 1 when A is non-negative, B is negative and D is negative. Otherwise V is 0.
- R6: C is 1 when any of these holds: A is negative and B is non-negative; A is negative and D is non-negative; B is non-negative and D is non-negative. This equals the unsigned test A >= B.
- R7: Select value 4 (instruction bits 7:5) picks the 32-bit compare. It uses bits 31:0 of each register, and the upper halves have no effect on the result.
- R8: Select value 5 (instruction bits 7:5) picks the 64-bit compare over the whole register as a signed value.
- R9: The index of A comes from instruction bits 19:16 and the index of B from bits 3:0. Instruction bits outside 19:16, 7:5 and 3:0 have no effect.
- R10: A request with any select value other than 4 or 5 gives `illegal_op` high for one cycle in the next cycle. In that cycle `flags_valid` is low and `flags_word` is zero. `flags_word` is zero in every cycle where `flags_valid` is low.
- R11: When both indices name the same register, the word has Z=1, C=1, N=0 and V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Compare request strobe |
| insn | input | 32 | Instruction word carrying the select and the two indices |
| rf_image | input | NREGS*XLEN (1024) | Register file contents, entry i in bits i*XLEN +: XLEN |
| flags_valid | output | 1 | One-cycle pulse marking a valid status word |
| flags_word | output | 32 | Status word, flags in bits 31:28 |
| illegal_op | output | 1 | One-cycle pulse for an unsupported select |

## Verification
The bench loads sixteen registers with values that sit on the sign and carry boundaries at both widths. These include zero, plus and minus one, the most positive and most negative values, and words whose low half is a boundary while the upper half is arbitrary. It then compares every ordered pair of registers in both modes. A design that swapped the carry sense, for example by testing for borrow instead of not-borrow, would fail every pair where A is unsigned-above B. A design that took the overflow from the wrong width would set V for pairs that straddle bit 31 in wide mode. A design that let the upper half leak into the narrow compare would clear Z on registers whose low halves match but whose upper halves differ. The bench fills the ignored instruction bits with changing patterns and sweeps all six unsupported select values, so a decoder that looked at the wrong field would show up as flags on illegal requests or as wrong operands.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  localparam int WORDW    = 32;
  localparam int SEL_LO   = 5;
  localparam int SEL_W    = 3;
  localparam int SRCA_LO  = 16;
  localparam int SRCB_LO  = 0;
  localparam int BIT_N    = 31;
  localparam int BIT_Z    = 30;
  localparam int BIT_C    = 29;
  localparam int BIT_V    = 28;
  localparam logic [SEL_W-1:0] OP_CMP_NARROW = 3'd4;
  localparam logic [SEL_W-1:0] OP_CMP_WIDE   = 3'd5;

  typedef enum logic [1:0] {
    MODE_NARROW = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_BAD    = 2'd2
  } cmpf_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cmpf_flags_t;
endpackage

// File: rtl/cmpf_decode.sv
module cmpf_decode
  import cmpf_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic [WORDW-1:0] insn,
  output logic [IDXW-1:0]  idx_a,
  output logic [IDXW-1:0]  idx_b,
  output cmpf_mode_e       mode
);
  logic [SEL_W-1:0] sel;
  logic             unused_insn_bits;

  assign sel   = insn[SEL_LO +: SEL_W];
  assign idx_a = insn[SRCA_LO +: IDXW];
  assign idx_b = insn[SRCB_LO +: IDXW];
  assign unused_insn_bits = ^insn;

  always_comb begin
    unique case (sel)
      OP_CMP_NARROW: mode = MODE_NARROW;
      OP_CMP_WIDE:   mode = MODE_WIDE;
      default:       mode = MODE_BAD;
    endcase
  end
endmodule

// File: rtl/cmpf_operand_mux.sv
module cmpf_operand_mux #(
  parameter int NREGS = 16,
  parameter int XLEN  = 64,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic [NREGS*XLEN-1:0] rf_image,
  input  logic [IDXW-1:0]       idx,
  output logic [XLEN-1:0]       data
);
  logic [XLEN-1:0] entry [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_unpack
    assign entry[g] = rf_image[g*XLEN +: XLEN];
  end

  assign data = entry[idx];
endmodule

// File: rtl/cmpf_flag_core.sv
module cmpf_flag_core
  import cmpf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output cmpf_flags_t  flags
);
  logic [W-1:0] diff;
  logic         a_neg, b_neg, r_neg;

  assign diff  = opa - opb;
  assign a_neg = opa[W-1];
  assign b_neg = opb[W-1];
  assign r_neg = diff[W-1];

  always_comb begin
    flags.n = r_neg;
    flags.z = (diff == '0);
    flags.v = (a_neg & ~b_neg & ~r_neg) | (~a_neg & b_neg & r_neg);
    flags.c = (a_neg & ~b_neg) | (a_neg & ~r_neg) | (~b_neg & ~r_neg);
  end
endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
  import cmpf_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int XLEN  = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [WORDW-1:0]      insn,
  input  logic [NREGS*XLEN-1:0] rf_image,
  output logic                  flags_valid,
  output logic [WORDW-1:0]      flags_word,
  output logic                  illegal_op
);
  localparam int IDXW = $clog2(NREGS);
  localparam int HALF = XLEN / 2;

  logic [IDXW-1:0] idx_a, idx_b;
  cmpf_mode_e      mode;
  logic [XLEN-1:0] opa, opb;
  cmpf_flags_t     fl_narrow, fl_wide, fl_sel;
  logic [WORDW-1:0] word_next;
  logic            legal;

  cmpf_decode #(.IDXW(IDXW)) u_dec (
    .insn  (insn),
    .idx_a (idx_a),
    .idx_b (idx_b),
    .mode  (mode)
  );

  cmpf_operand_mux #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) u_mux_a (
    .rf_image (rf_image),
    .idx      (idx_a),
    .data     (opa)
  );

  cmpf_operand_mux #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) u_mux_b (
    .rf_image (rf_image),
    .idx      (idx_b),
    .data     (opb)
  );

  cmpf_flag_core #(.W(HALF)) u_core_narrow (
    .opa   (opa[HALF-1:0]),
    .opb   (opb[HALF-1:0]),
    .flags (fl_narrow)
  );

  cmpf_flag_core #(.W(XLEN)) u_core_wide (
    .opa   (opa),
    .opb   (opb),
    .flags (fl_wide)
  );

  assign legal  = (mode != MODE_BAD);
  assign fl_sel = (mode == MODE_WIDE) ? fl_wide : fl_narrow;

  always_comb begin
    word_next        = '0;
    word_next[BIT_N] = fl_sel.n;
    word_next[BIT_Z] = fl_sel.z;
    word_next[BIT_C] = fl_sel.c;
    word_next[BIT_V] = fl_sel.v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_valid <= 1'b0;
      illegal_op  <= 1'b0;
      flags_word  <= '0;
    end else begin
      flags_valid <= req_valid & legal;
      illegal_op  <= req_valid & ~legal;
      flags_word  <= (req_valid & legal) ? word_next : '0;
    end
  end
endmodule

// File: rtl/cmpf_unit_chk.sv
module cmpf_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] insn,
  input logic        flags_valid,
  input logic [31:0] flags_word,
  input logic        illegal_op
);
  logic legal_sel;
  assign legal_sel = (insn[7:5] == 3'd4) || (insn[7:5] == 3'd5);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!flags_valid && !illegal_op && flags_word == 32'h0));

  a_r2_result_next: assert property (@(posedge clk) disable iff (rst)
    (req_valid && legal_sel) |=> (flags_valid && !illegal_op));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!flags_valid && !illegal_op));

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    flags_valid |-> (flags_word[27:0] == 28'h0));

  a_r4_n_z_exclusive: assert property (@(posedge clk) disable iff (rst)
    flags_valid |-> !(flags_word[31] && flags_word[30]));

  a_r10_illegal_next: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !legal_sel) |=> (illegal_op && !flags_valid));

  a_r10_word_clear: assert property (@(posedge clk) disable iff (rst)
    !flags_valid |-> (flags_word == 32'h0));

  a_r11_zero_means_equal: assert property (@(posedge clk) disable iff (rst)
    (flags_valid && flags_word[30]) |-> (flags_word[29] && !flags_word[28]));
endmodule

bind cmpf_unit cmpf_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .insn        (insn),
  .flags_valid (flags_valid),
  .flags_word  (flags_word),
  .illegal_op  (illegal_op)
);

// File: tb/cmpf_unit_test.sv
module cmpf_unit_test;
  localparam int NREGS = 16;
  localparam int XLEN  = 64;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  req_valid = 1'b0;
  logic [31:0]           insn = 32'h0;
  logic [NREGS*XLEN-1:0] rf_image = '0;
  logic                  flags_valid;
  logic [31:0]           flags_word;
  logic                  illegal_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] regs [NREGS];

  always #4 clk = ~clk;

  cmpf_unit #(.NREGS(NREGS), .XLEN(XLEN)) uut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .insn        (insn),
    .rf_image    (rf_image),
    .flags_valid (flags_valid),
    .flags_word  (flags_word),
    .illegal_op  (illegal_op)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [63:0] a, input logic [63:0] b, input bit wide);
    logic [64:0] sa, sb, sd;
    logic n, z, c, v;
    if (wide) begin
      sa = {a[63], a};
      sb = {b[63], b};
      sd = sa - sb;
      n = sd[63];
      z = (sd[63:0] == 64'h0);
      v = sd[64] ^ sd[63];
      c = (a >= b);
    end else begin
      sa = {{33{a[31]}}, a[31:0]};
      sb = {{33{b[31]}}, b[31:0]};
      sd = sa - sb;
      n = sd[31];
      z = (sd[31:0] == 32'h0);
      v = sd[32] ^ sd[31];
      c = (a[31:0] >= b[31:0]);
    end
    return {n, z, c, v, 28'h0};
  endfunction

  function automatic logic [63:0] seed_value(input int i);
    case (i)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h7FFF_FFFF_FFFF_FFFF;
      4:  return 64'h8000_0000_0000_0000;
      5:  return 64'h0000_0000_7FFF_FFFF;
      6:  return 64'h0000_0000_8000_0000;
      7:  return 64'hFFFF_FFFF_8000_0000;
      8:  return 64'h1234_5678_0000_0000;
      9:  return 64'hDEAD_BEEF_0000_0001;
      10: return 64'h0000_0001_FFFF_FFFF;
      11: return 64'h7FFF_FFFF_FFFF_FFFE;
      12: return 64'h8000_0000_0000_0001;
      13: return 64'h0000_0000_0000_0002;
      14: return 64'hFFFF_FFFF_FFFF_FFFE;
      default: return 64'h5555_AAAA_AAAA_5555;
    endcase
  endfunction

  function automatic logic [31:0] make_insn(input int ia, input int ib, input logic [2:0] sel, input int k);
    logic [31:0] filler;
    filler = (k % 3 == 0) ? 32'h0 : ((k % 3 == 1) ? 32'hFFFF_FFFF : 32'hA5C3_5A96);
    filler = filler & ~32'h000F_00EF;
    return filler | (32'(ia) << 16) | (32'(sel) << 5) | 32'(ib);
  endfunction

  // Issue one request, then sample one cycle later away from the edge.
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    insn = w;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_cmp(input int ia, input int ib, input bit wide, input int k, input string tag);
    logic [31:0] exp;
    exp = model(regs[ia], regs[ib], wide);
    issue(make_insn(ia, ib, wide ? 3'd5 : 3'd4, k));
    chk({tag, " R2 valid"}, {63'h0, flags_valid}, 64'h1);
    chk({tag, " R4 N/Z"}, {62'h0, flags_word[31:30]}, {62'h0, exp[31:30]});
    chk({tag, " R6 C"}, {63'h0, flags_word[29]}, {63'h0, exp[29]});
    chk({tag, " R5 V"}, {63'h0, flags_word[28]}, {63'h0, exp[28]});
    chk({tag, " R3 low bits"}, {36'h0, flags_word[27:0]}, 64'h0);
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) begin
      regs[i] = seed_value(i);
      rf_image[i*XLEN +: XLEN] = regs[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", {63'h0, flags_valid}, 64'h0);
    chk("R1 reset illegal", {63'h0, illegal_op}, 64'h0);
    chk("R1 reset word", {32'h0, flags_word}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset word", {32'h0, flags_word}, 64'h0);

    // R7 and R8: full sweep of all ordered pairs in both modes, R9 filler varies
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < NREGS; a++) begin
        for (int b = 0; b < NREGS; b++) begin
          run_cmp(a, b, m == 1, a * NREGS + b, m == 1 ? "R8 wide" : "R7 narrow");
        end
      end
    end

    // R2: idle cycle after the last pulse gives no output
    @(negedge clk);
    chk("R2 idle valid", {63'h0, flags_valid}, 64'h0);
    chk("R2 idle illegal", {63'h0, illegal_op}, 64'h0);

    // R7: upper half must not matter in narrow mode (reg 8 low half is zero)
    issue(make_insn(8, 0, 3'd4, 1));
    chk("R7 upper half ignored", {32'h0, flags_word}, 64'h0000_0000_6000_0000);
    issue(make_insn(8, 0, 3'd5, 1));
    chk("R8 upper half counts", {32'h0, flags_word}, 64'h0000_0000_2000_0000);

    // R9: operand order comes from 19:16 (A) and 3:0 (B)
    issue(make_insn(1, 0, 3'd5, 2));
    chk("R9 order a=1 b=0", {32'h0, flags_word}, 64'h0000_0000_2000_0000);
    issue(make_insn(0, 1, 3'd5, 2));
    chk("R9 order a=0 b=1", {32'h0, flags_word}, 64'h0000_0000_8000_0000);

    // R5: wide overflow, most negative minus one
    issue(make_insn(4, 1, 3'd5, 0));
    chk("R5 wide overflow", {32'h0, flags_word}, 64'h0000_0000_3000_0000);

    // R11: same register in both slots
    for (int i = 0; i < NREGS; i++) begin
      issue(make_insn(i, i, (i % 2) ? 3'd5 : 3'd4, i));
      chk("R11 self compare", {32'h0, flags_word}, 64'h0000_0000_6000_0000);
    end

    // R10: every unsupported select
    for (int s = 0; s < 8; s++) begin
      if (s == 4 || s == 5) continue;
      issue(make_insn(2, 3, 3'(s), s));
      chk("R10 illegal pulse", {63'h0, illegal_op}, 64'h1);
      chk("R10 no valid", {63'h0, flags_valid}, 64'h0);
      chk("R10 word zero", {32'h0, flags_word}, 64'h0);
    end
    @(negedge clk);
    chk("R10 illegal one cycle", {63'h0, illegal_op}, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule